// File: doc/BRIEF.md
# Counting Semaphore Memory

A bus slave holding a bank of counting semaphores. A single bus access can return a semaphore's current count and reduce it in the same access. The low bits of the address do not select a location. Instead they carry an operand: how far the addressed count should drop. Software can therefore acquire from a semaphore with one read. It gets back the value held before the access, so it can tell whether the acquire found any units to take.

The same address-encoded decrement is honoured on write cycles. A write whose amount field is zero loads the written data as the new count, which is how counts are initialised. The slave follows a simple Wishbone-style handshake: cycle, strobe, write enable, address, write data, read data and a registered acknowledge.

Top module: `sem_mem`

## Requirements
- R1: After reset every count is zero, and `ack_o` is low.
- R2: An access is accepted when `cyc_i` and `stb_i` are both high while `ack_o` is low. `ack_o` is high for exactly one cycle, in the cycle after acceptance. A strobe held across the acknowledge is accepted again only in the cycle after the acknowledge, so it produces one acknowledge every other cycle.
- R3: While `ack_o` is high, `dat_o` holds the addressed count as it was before the access updated it. This holds for reads and for writes.
- R4: `adr_i[11:4]` selects one of 256 semaphores. `adr_i[3:0]` is the decrement amount, an unsigned value from 0 to 15.
- R5: A read with a nonzero amount replaces the count with the count minus the amount.
- R6: A decrement never wraps. If the amount is larger than the count, the count becomes zero.
- R7: A read with amount zero leaves the count unchanged.
- R8: A write with amount zero loads `dat_i` as the new count.
- R9: A write with a nonzero amount decrements exactly as a read does, and `dat_i` has no effect on the stored count.
- R10: When no access is accepted, no count changes and no acknowledge is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | 12 | [11:4] semaphore index, [3:0] decrement amount |
| dat_i | input | 16 | Write data, used only when the amount is zero |
| dat_o | output | 16 | Count before the access, valid with ack_o |
| ack_o | output | 1 | One-cycle acknowledge |

## Verification
The load path and the decrement path can both be requested in a single cycle. This happens when a write carries nonzero data and also a nonzero amount. The bench provokes this with random write data on decrementing writes. It then reads the semaphore back and requires the stored count to follow the saturating decrement, with the data left out. A second overlap is a strobe held across an acknowledge, where a completing access and the next acceptance meet. The bench holds the strobe for four cycles and requires the acknowledges to alternate. It also requires exactly two decrements to be applied.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OP_PEEK = 2'd0,  // no update
    OP_LOAD = 2'd1,  // write data becomes count
    OP_TAKE = 2'd2   // saturating decrement
  } sem_op_e;
endpackage

// File: rtl/sem_decode.sv
module sem_decode
  import sem_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int AMT_W = 4
) (
  input  logic                   we_i,
  input  logic [IDX_W+AMT_W-1:0] adr_i,
  output logic [IDX_W-1:0]       idx_o,
  output logic [AMT_W-1:0]       amt_o,
  output sem_op_e                op_o
);
  always_comb begin
    idx_o = adr_i[IDX_W+AMT_W-1:AMT_W];
    amt_o = adr_i[AMT_W-1:0];
    if (amt_o != '0)  op_o = OP_TAKE;
    else if (we_i)    op_o = OP_LOAD;
    else              op_o = OP_PEEK;
  end
endmodule

// File: rtl/sem_update.sv
module sem_update
  import sem_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int AMT_W = 4
) (
  input  logic             accept_i,
  input  sem_op_e          op_i,
  input  logic [CNT_W-1:0] cur_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic [CNT_W-1:0] wdat_i,
  output logic             upd_o,
  output logic [CNT_W-1:0] nxt_o
);
  localparam int PAD_W = CNT_W - AMT_W;

  logic [CNT_W-1:0] amt_ext;
  assign amt_ext = {{PAD_W{1'b0}}, amt_i};

  always_comb begin
    upd_o = 1'b0;
    nxt_o = cur_i;
    if (accept_i) begin
      case (op_i)
        OP_LOAD: begin
          upd_o = 1'b1;
          nxt_o = wdat_i;
        end
        OP_TAKE: begin
          upd_o = 1'b1;
          nxt_o = (cur_i > amt_ext) ? cur_i - amt_ext : '0;
        end
        default: begin
          upd_o = 1'b0;
          nxt_o = cur_i;
        end
      endcase
    end
  end
endmodule

// File: rtl/sem_store.sv
module sem_store #(
  parameter int DEPTH = 256,
  parameter int CNT_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [CNT_W-1:0] wdat_i,
  output logic [CNT_W-1:0] rdat_o
);
  logic [CNT_W-1:0] cnt_q [DEPTH];

  assign rdat_o = cnt_q[idx_i];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  cnt_q[g] <= '0;
      else if (we_i && (idx_i == IDX_W'(g)))        cnt_q[g] <= wdat_i;
    end
  end
endmodule

// File: rtl/sem_mem.sv
module sem_mem
  import sem_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CNT_W = 16,
  parameter int AMT_W = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int ADR_W = IDX_W + AMT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_i,
  input  logic             stb_i,
  input  logic             we_i,
  input  logic [ADR_W-1:0] adr_i,
  input  logic [CNT_W-1:0] dat_i,
  output logic [CNT_W-1:0] dat_o,
  output logic             ack_o
);
  logic             accept;
  logic [IDX_W-1:0] idx;
  logic [AMT_W-1:0] amt;
  sem_op_e          op;
  logic [CNT_W-1:0] cur_cnt;
  logic [CNT_W-1:0] nxt_cnt;
  logic             upd_en;
  logic             ack_q;
  logic [CNT_W-1:0] rdat_q;

  // one access per acknowledge; a held strobe waits out the ack cycle
  assign accept = cyc_i && stb_i && !ack_q;

  sem_decode #(.IDX_W(IDX_W), .AMT_W(AMT_W)) u_dec (
    .we_i  (we_i),
    .adr_i (adr_i),
    .idx_o (idx),
    .amt_o (amt),
    .op_o  (op)
  );

  sem_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (upd_en),
    .idx_i  (idx),
    .wdat_i (nxt_cnt),
    .rdat_o (cur_cnt)
  );

  sem_update #(.CNT_W(CNT_W), .AMT_W(AMT_W)) u_upd (
    .accept_i (accept),
    .op_i     (op),
    .cur_i    (cur_cnt),
    .amt_i    (amt),
    .wdat_i   (dat_i),
    .upd_o    (upd_en),
    .nxt_o    (nxt_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= 1'b0;
      rdat_q <= '0;
    end else begin
      ack_q <= accept;
      if (accept) rdat_q <= cur_cnt;
    end
  end

  assign ack_o = ack_q;
  assign dat_o = rdat_q;
endmodule

// File: rtl/sem_mem_chk.sv
module sem_mem_chk
  import sem_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cyc_i,
  input logic             stb_i,
  input logic             ack_o,
  input logic [CNT_W-1:0] dat_o,
  input logic             accept,
  input sem_op_e          op,
  input logic [CNT_W-1:0] cur_cnt,
  input logic [CNT_W-1:0] nxt_cnt,
  input logic             upd_en
);
  p_ack_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> ack_o);

  p_ack_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cyc_i && stb_i) |=> !ack_o);

  p_idle_no_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |-> !upd_en);

  p_old_value_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (dat_o == $past(cur_cnt)));

  p_peek_no_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && op == OP_PEEK) |-> !upd_en);

  p_take_shrinks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en && op == OP_TAKE) |-> (nxt_cnt <= cur_cnt));
endmodule

bind sem_mem sem_mem_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cyc_i   (cyc_i),
  .stb_i   (stb_i),
  .ack_o   (ack_o),
  .dat_o   (dat_o),
  .accept  (accept),
  .op      (op),
  .cur_cnt (cur_cnt),
  .nxt_cnt (nxt_cnt),
  .upd_en  (upd_en)
);

// File: tb/sem_mem_test.sv
module sem_mem_test;
  localparam int N = 256;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cyc_i = 1'b0;
  logic        stb_i = 1'b0;
  logic        we_i = 1'b0;
  logic [11:0] adr_i = '0;
  logic [15:0] dat_i = '0;
  logic [15:0] dat_o;
  logic        ack_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] model [N];

  always #2 clk_i = ~clk_i;

  sem_mem uut (.*);

  function automatic logic [15:0] sat_dec(logic [15:0] c, logic [3:0] a);
    return (c > {12'd0, a}) ? c - {12'd0, a} : 16'd0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one access; checks ack, returned data, ack drop; updates model
  task automatic access(string req, logic we, logic [7:0] idx, logic [3:0] amt,
                        logic [15:0] wd);
    logic [15:0] old;
    old = model[idx];
    @(negedge clk_i);
    cyc_i = 1'b1; stb_i = 1'b1; we_i = we; adr_i = {idx, amt}; dat_i = wd;
    @(negedge clk_i);
    check({req, "/R2 ack"}, 32'(ack_o), 32'd1);
    check({req, "/R3 data"}, 32'(dat_o), 32'(old));
    cyc_i = 1'b0; stb_i = 1'b0;
    @(negedge clk_i);
    check({req, "/R2 ack drop"}, 32'(ack_o), 32'd0);
    if (amt != 0)  model[idx] = sat_dec(old, amt);
    else if (we)   model[idx] = wd;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = '0;
    void'($urandom(32'h5e3a_0117));
    #10 rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 ack idle", 32'(ack_o), 32'd0);
    // R1: counts zero after reset
    access("R1 idx0", 1'b0, 8'd0, 4'd0, '0);
    access("R1 idx255", 1'b0, 8'd255, 4'd0, '0);
    // R8 load, R4 index selection
    access("R8 load", 1'b1, 8'd17, 4'd0, 16'd10);
    access("R4 neighbour", 1'b0, 8'd16, 4'd0, '0);
    // R5 decrement by 3 then R7 peek shows 7
    access("R5 take", 1'b0, 8'd17, 4'd3, '0);
    access("R7 peek", 1'b0, 8'd17, 4'd0, '0);
    access("R7 peek again", 1'b0, 8'd17, 4'd0, '0);
    // R6 saturation: 7 - 15 -> 0
    access("R6 sat", 1'b0, 8'd17, 4'd15, '0);
    access("R6 zero", 1'b0, 8'd17, 4'd0, '0);
    access("R6 take at zero", 1'b0, 8'd17, 4'd1, '0);
    // R9: write with amount ignores data
    access("R9 load", 1'b1, 8'd40, 4'd0, 16'h0100);
    access("R9 wdec", 1'b1, 8'd40, 4'd5, 16'hbeef);
    access("R9 result", 1'b0, 8'd40, 4'd0, '0);
    check("R9 value", 32'(model[40]), 32'h00fb);
    // R10: strobe without cycle, and cycle without strobe
    @(negedge clk_i);
    cyc_i = 1'b0; stb_i = 1'b1; we_i = 1'b1; adr_i = {8'd40, 4'd0}; dat_i = 16'h1234;
    @(negedge clk_i);
    check("R10 no ack stb only", 32'(ack_o), 32'd0);
    cyc_i = 1'b1; stb_i = 1'b0; adr_i = {8'd40, 4'd9};
    @(negedge clk_i);
    check("R10 no ack cyc only", 32'(ack_o), 32'd0);
    cyc_i = 1'b0;
    access("R10 unchanged", 1'b0, 8'd40, 4'd0, '0);
    // R2: held strobe, amount 1, four cycles -> acks 1,0,1,0, two decrements
    access("R2 prep", 1'b1, 8'd3, 4'd0, 16'd20);
    @(negedge clk_i);
    cyc_i = 1'b1; stb_i = 1'b1; we_i = 1'b0; adr_i = {8'd3, 4'd1};
    @(negedge clk_i); check("R2 held c1", 32'(ack_o), 32'd1);
    check("R2 held d1", 32'(dat_o), 32'd20);
    @(negedge clk_i); check("R2 held c2", 32'(ack_o), 32'd0);
    @(negedge clk_i); check("R2 held c3", 32'(ack_o), 32'd1);
    check("R2 held d3", 32'(dat_o), 32'd19);
    cyc_i = 1'b0; stb_i = 1'b0;
    @(negedge clk_i); check("R2 held c4", 32'(ack_o), 32'd0);
    model[3] = 16'd18;
    access("R2 held result", 1'b0, 8'd3, 4'd0, '0);
    // random mix on a few hot locations plus the full range
    for (int k = 0; k < 400; k++) begin
      logic [7:0]  ri;
      logic [3:0]  ra;
      logic        rw;
      logic [15:0] rd;
      ri = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 6);
      ra = ($urandom % 3 == 0) ? 4'd0 : 4'($urandom);
      rw = 1'($urandom);
      rd = ($urandom % 2 == 0) ? 16'($urandom % 40) : 16'($urandom);
      access(rw ? "R9 rnd write" : "R5 rnd read", rw, ri, ra, rd);
    end
    for (int i = 0; i < 6; i++) access("R3 final", 1'b0, 8'(i), 4'd0, '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule